// File: doc/BRIEF.md
# Watchpoint Trigger Condition Unit

This block decides when an on-chip capture buffer should record. It watches a set of probed signals and one state signal, all sampled on cycles where a sample strobe is high, and emits a one-clock trigger pulse when the programmed condition is met. There are several watchpoints and several breakpoints. Each watchpoint works in one of two modes. In level mode it matches when its signal equals a programmed value. In change mode it matches when its signal held value A on one sample and holds value B on the next sample. A breakpoint matches when the shared state signal equals a programmed state code. A breakpoint only requests a capture and never stalls the observed logic.

Every enabled condition feeds one AND, so a complex trigger such as "state is S and ready is 1" fires only when all enabled terms are true on the same sample. The host writes each condition word through a simple write port and then pulses `arm`. The unit gives at most one trigger per arm and then waits for the next arm.

Top module: `wpt_trigger_unit`

## Requirements
- R1: While and after synchronous reset, `trg` and `armed` are 0 and every watchpoint and breakpoint is disabled.
- R2: A cycle with `arm` high makes `armed` 1 on the next cycle, even if the unit is idle or has just fired. No sample is evaluated in the arm cycle. Without an arm the unit never fires.
- R3: A watchpoint in level mode (mode bit 0) matches on a sample where its signal equals field A.
- R4: A watchpoint in change mode (mode bit 1) matches only on a sample where its signal equals field B and the previous evaluated sample of that signal equalled field A.
- R5: Arming discards the stored previous samples, so the first sample after an arm can never complete a change-mode match.
- R6: A breakpoint matches when the state signal `st_sig` equals its programmed state code.
- R7: The trigger condition is the AND of all enabled conditions. A disabled condition counts as true.
- R8: If no condition is enabled the unit never fires and stays armed.
- R9: `trg` is high for exactly one clock, in the cycle after the deciding sample edge. In that cycle `armed` is 0, and no further trigger occurs until the next arm.
- R10: Only cycles with `smp_en` high while armed are samples. Other cycles neither match nor update the stored previous sample.
- R11: A write with `cfg_we` to address i < NUM_WP programs watchpoint i with A in bits [W-1:0], B in bits [2W-1:W], mode in bit 2W and enable in bit 2W+1, where W is the signal width. Address NUM_WP+j programs breakpoint j with the state code in the low bits and enable in bit 2W+1. Writes to any higher address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Condition word write strobe |
| cfg_addr | input | ADDR_W | Condition slot select |
| cfg_wdata | input | 2*SIG_W+2 | Condition word |
| arm | input | 1 | Run command: arm the unit |
| smp_en | input | 1 | Sample strobe |
| wp_sig | input | NUM_WP*SIG_W | Probed signals, watchpoint i at slice i |
| st_sig | input | ST_W | Probed state signal for breakpoints |
| trg | output | 1 | One-clock trigger pulse |
| armed | output | 1 | Unit is waiting for its trigger |

## Verification
The hardest situation to reach is a change-mode match that straddles an event which must break it. Examples are an arm between the A sample and the B sample, or strobe-low cycles that carry a different value between them. Directed sequences put value A on the signal before the arm and B right after it. They also insert unsampled cycles holding other values between A and B. A random phase then draws signal values from a four-value range with random modes, enables, arms and strobe gaps, so that such straddles and multi-term ANDs come up often.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    typedef enum logic {
        WM_LEVEL  = 1'b0,
        WM_CHANGE = 1'b1
    } wm_mode_e;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_ARMED = 2'd1,
        TS_FIRE  = 2'd2
    } tstate_e;

    function automatic int cfg_width(input int sw);
        return 2 * sw + 2;
    endfunction

    function automatic int en_pos(input int sw);
        return 2 * sw + 1;
    endfunction

    function automatic int mode_pos(input int sw);
        return 2 * sw;
    endfunction

endpackage

// File: rtl/wpt_cfg_regs.sv
module wpt_cfg_regs
    import wpt_pkg::*;
#(
    parameter int NUM_WP = 4,
    parameter int NUM_BP = 2,
    parameter int SIG_W  = 8,
    parameter int ST_W   = 4,
    parameter int ADDR_W = 3,
    parameter int CFG_W  = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output logic [NUM_WP-1:0]       wp_en,
    output wm_mode_e                wp_mode [NUM_WP],
    output logic [NUM_WP*SIG_W-1:0] wp_a,
    output logic [NUM_WP*SIG_W-1:0] wp_b,
    output logic [NUM_BP-1:0]       bp_en,
    output logic [NUM_BP*ST_W-1:0]  bp_val
);
    localparam int EN_B   = en_pos(SIG_W);
    localparam int MODE_B = mode_pos(SIG_W);

    for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
        logic sel;
        assign sel = cfg_we && (int'(cfg_addr) == i);
        always_ff @(posedge clk) begin
            if (rst) begin
                wp_en[i]              <= 1'b0;
                wp_mode[i]            <= WM_LEVEL;
                wp_a[i*SIG_W +: SIG_W] <= '0;
                wp_b[i*SIG_W +: SIG_W] <= '0;
            end else if (sel) begin
                wp_en[i]              <= cfg_wdata[EN_B];
                wp_mode[i]            <= wm_mode_e'(cfg_wdata[MODE_B]);
                wp_a[i*SIG_W +: SIG_W] <= cfg_wdata[SIG_W-1:0];
                wp_b[i*SIG_W +: SIG_W] <= cfg_wdata[2*SIG_W-1:SIG_W];
            end
        end
    end

    for (genvar j = 0; j < NUM_BP; j++) begin : g_bp
        logic sel;
        assign sel = cfg_we && (int'(cfg_addr) == NUM_WP + j);
        always_ff @(posedge clk) begin
            if (rst) begin
                bp_en[j]              <= 1'b0;
                bp_val[j*ST_W +: ST_W] <= '0;
            end else if (sel) begin
                bp_en[j]              <= cfg_wdata[EN_B];
                bp_val[j*ST_W +: ST_W] <= cfg_wdata[ST_W-1:0];
            end
        end
    end

    // R1: right after reset no condition is enabled
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (wp_en == '0) && (bp_en == '0));

endmodule

// File: rtl/wpt_watch.sv
module wpt_watch
    import wpt_pkg::*;
#(
    parameter int SIG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  wm_mode_e         mode,
    input  logic [SIG_W-1:0] val_a,
    input  logic [SIG_W-1:0] val_b,
    input  logic [SIG_W-1:0] sig,
    input  logic             smp,
    input  logic             clr,
    output logic             hit
);
    logic [SIG_W-1:0] prev_q;
    logic             prev_vld_q;
    logic             lvl_match;
    logic             chg_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= '0;
            prev_vld_q <= 1'b0;
        end else if (clr) begin
            prev_vld_q <= 1'b0;
        end else if (smp) begin
            prev_q     <= sig;
            prev_vld_q <= 1'b1;
        end
    end

    always_comb begin
        lvl_match = (sig == val_a);
        chg_match = prev_vld_q && (prev_q == val_a) && (sig == val_b);
        if (!en) begin
            hit = 1'b1;
        end else if (mode == WM_CHANGE) begin
            hit = chg_match;
        end else begin
            hit = lvl_match;
        end
    end

    // R5: the sample right after an arm cannot finish a change-mode match
    p_no_first_change_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> !chg_match);

    // R10: the stored sample holds across cycles that are not samples
    p_prev_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!smp && !clr) |=> $stable(prev_q) && $stable(prev_vld_q));

endmodule

// File: rtl/wpt_break.sv
module wpt_break #(
    parameter int ST_W = 4
) (
    input  logic            en,
    input  logic [ST_W-1:0] code,
    input  logic [ST_W-1:0] st,
    output logic            hit
);
    always_comb begin
        hit = !en || (st == code);
    end
endmodule

// File: rtl/wpt_ctrl.sv
module wpt_ctrl
    import wpt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic smp,
    input  logic cond_ok,
    output logic trg,
    output logic armed
);
    tstate_e st_q;
    tstate_e st_d;

    always_comb begin
        st_d = st_q;
        if (arm) begin
            st_d = TS_ARMED;
        end else begin
            unique case (st_q)
                TS_ARMED: if (smp && cond_ok) st_d = TS_FIRE;
                TS_FIRE:  st_d = TS_IDLE;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= TS_IDLE;
        else     st_q <= st_d;
    end

    assign trg   = (st_q == TS_FIRE);
    assign armed = (st_q == TS_ARMED);

    // R9: the trigger lasts a single clock
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        trg |=> !trg);

    // R9: the unit is disarmed while the trigger is high
    p_disarm_on_fire_r9: assert property (@(posedge clk) disable iff (rst)
        trg |-> !armed);

    // R2: an arm request always leaves the unit armed
    p_arm_takes_r2: assert property (@(posedge clk) disable iff (rst)
        arm |=> armed);

    // R10: a trigger follows a sample cycle
    p_fire_on_sample_r10: assert property (@(posedge clk) disable iff (rst)
        trg |-> $past(smp));

endmodule

// File: rtl/wpt_trigger_unit.sv
module wpt_trigger_unit
    import wpt_pkg::*;
#(
    parameter int NUM_WP = 4,
    parameter int NUM_BP = 2,
    parameter int SIG_W  = 8,
    parameter int ST_W   = 4,
    parameter int ADDR_W = $clog2(NUM_WP + NUM_BP + 1),
    parameter int CFG_W  = cfg_width(SIG_W)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [CFG_W-1:0]        cfg_wdata,
    input  logic                    arm,
    input  logic                    smp_en,
    input  logic [NUM_WP*SIG_W-1:0] wp_sig,
    input  logic [ST_W-1:0]         st_sig,
    output logic                    trg,
    output logic                    armed
);
    logic [NUM_WP-1:0]       wp_en;
    wm_mode_e                wp_mode [NUM_WP];
    logic [NUM_WP*SIG_W-1:0] wp_a;
    logic [NUM_WP*SIG_W-1:0] wp_b;
    logic [NUM_BP-1:0]       bp_en;
    logic [NUM_BP*ST_W-1:0]  bp_val;
    logic [NUM_WP-1:0]       wp_hit;
    logic [NUM_BP-1:0]       bp_hit;
    logic                    smp;
    logic                    any_en;
    logic                    cond_ok;

    assign smp = smp_en && armed && !arm;

    wpt_cfg_regs #(
        .NUM_WP(NUM_WP), .NUM_BP(NUM_BP), .SIG_W(SIG_W),
        .ST_W(ST_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W)
    ) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .wp_en(wp_en), .wp_mode(wp_mode),
        .wp_a(wp_a), .wp_b(wp_b), .bp_en(bp_en), .bp_val(bp_val)
    );

    for (genvar i = 0; i < NUM_WP; i++) begin : g_watch
        wpt_watch #(.SIG_W(SIG_W)) u_watch (
            .clk(clk), .rst(rst), .en(wp_en[i]), .mode(wp_mode[i]),
            .val_a(wp_a[i*SIG_W +: SIG_W]), .val_b(wp_b[i*SIG_W +: SIG_W]),
            .sig(wp_sig[i*SIG_W +: SIG_W]), .smp(smp), .clr(arm),
            .hit(wp_hit[i])
        );
    end

    for (genvar j = 0; j < NUM_BP; j++) begin : g_break
        wpt_break #(.ST_W(ST_W)) u_break (
            .en(bp_en[j]), .code(bp_val[j*ST_W +: ST_W]),
            .st(st_sig), .hit(bp_hit[j])
        );
    end

    assign any_en  = (|wp_en) || (|bp_en);
    assign cond_ok = any_en && (&wp_hit) && (&bp_hit);

    wpt_ctrl u_ctrl (
        .clk(clk), .rst(rst), .arm(arm), .smp(smp),
        .cond_ok(cond_ok), .trg(trg), .armed(armed)
    );

    // R8: a trigger needs at least one enabled condition
    p_need_enable_r8: assert property (@(posedge clk) disable iff (rst)
        trg |-> $past(any_en));

    // R7: every enabled breakpoint agreed on the deciding sample
    p_and_of_breaks_r7: assert property (@(posedge clk) disable iff (rst)
        trg |-> $past(&bp_hit));

endmodule

// File: tb/wpt_trigger_unit_bench.sv
module wpt_trigger_unit_bench;
    localparam int NW = 4;
    localparam int NB = 2;
    localparam int W  = 8;
    localparam int SW = 4;
    localparam int AW = $clog2(NW + NB + 1);
    localparam int CW = 2 * W + 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [AW-1:0] cfg_addr;
    logic [CW-1:0] cfg_wdata;
    logic          arm;
    logic          smp_en;
    logic [NW*W-1:0] wp_sig;
    logic [SW-1:0] st_sig;
    logic          trg;
    logic          armed;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // reference state
    bit          m_armed, m_trg;
    bit          m_en [NW];
    bit          m_mode [NW];
    bit [W-1:0]  m_a [NW];
    bit [W-1:0]  m_b [NW];
    bit [W-1:0]  m_prev [NW];
    bit          m_pv [NW];
    bit          m_ben [NB];
    bit [SW-1:0] m_bval [NB];

    always #4 clk = ~clk;

    wpt_trigger_unit #(.NUM_WP(NW), .NUM_BP(NB), .SIG_W(W), .ST_W(SW)) u_wpt_trigger_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .arm(arm), .smp_en(smp_en), .wp_sig(wp_sig),
        .st_sig(st_sig), .trg(trg), .armed(armed)
    );

    function automatic bit [CW-1:0] wp_word(bit en, bit md, bit [W-1:0] a, bit [W-1:0] b);
        return {en, md, b, a};
    endfunction

    function automatic bit [CW-1:0] bp_word(bit en, bit [SW-1:0] code);
        bit [CW-1:0] w = '0;
        w[CW-1] = en;
        w[SW-1:0] = code;
        return w;
    endfunction

    function automatic void model_reset();
        m_armed = 0; m_trg = 0;
        for (int i = 0; i < NW; i++) begin
            m_en[i] = 0; m_mode[i] = 0; m_a[i] = 0; m_b[i] = 0; m_prev[i] = 0; m_pv[i] = 0;
        end
        for (int j = 0; j < NB; j++) begin
            m_ben[j] = 0; m_bval[j] = 0;
        end
    endfunction

    function automatic void model_step(bit we, bit [AW-1:0] ad, bit [CW-1:0] wd,
                                       bit ar, bit se, bit [NW*W-1:0] sg, bit [SW-1:0] st);
        bit smp, ok, any;
        bit [W-1:0] s;
        smp = se && m_armed && !ar;
        ok = 1; any = 0;
        for (int i = 0; i < NW; i++) begin
            s = sg[i*W +: W];
            if (m_en[i]) begin
                any = 1;
                if (m_mode[i]) ok &= m_pv[i] && (m_prev[i] == m_a[i]) && (s == m_b[i]);
                else           ok &= (s == m_a[i]);
            end
        end
        for (int j = 0; j < NB; j++)
            if (m_ben[j]) begin
                any = 1;
                ok &= (st == m_bval[j]);
            end
        if (ar) begin
            m_armed = 1; m_trg = 0;
            for (int i = 0; i < NW; i++) m_pv[i] = 0;
        end else begin
            if (m_trg) m_trg = 0;
            if (smp && ok && any) begin
                m_trg = 1; m_armed = 0;
            end
            if (smp)
                for (int i = 0; i < NW; i++) begin
                    m_prev[i] = sg[i*W +: W]; m_pv[i] = 1;
                end
        end
        if (we) begin
            if (int'(ad) < NW) begin
                m_en[ad] = wd[CW-1]; m_mode[ad] = wd[CW-2];
                m_a[ad] = wd[W-1:0]; m_b[ad] = wd[2*W-1:W];
            end else if (int'(ad) < NW + NB) begin
                m_ben[int'(ad)-NW] = wd[CW-1];
                m_bval[int'(ad)-NW] = wd[SW-1:0];
            end
        end
    endfunction

    task automatic check(string tag);
        total++;
        if (trg !== m_trg || armed !== m_armed) begin
            bad++;
            $display("FAIL %s: trg/armed actual=%b%b expected=%b%b", tag, trg, armed, m_trg, m_armed);
        end
    endtask

    task automatic step(bit we, bit [AW-1:0] ad, bit [CW-1:0] wd, bit ar, bit se,
                        bit [NW*W-1:0] sg, bit [SW-1:0] st, string tag);
        cfg_we = we; cfg_addr = ad; cfg_wdata = wd; arm = ar; smp_en = se;
        wp_sig = sg; st_sig = st;
        model_step(we, ad, wd, ar, se, sg, st);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic wr(bit [AW-1:0] ad, bit [CW-1:0] wd, string tag);
        step(1, ad, wd, 0, 0, '0, '0, tag);
    endtask

    task automatic smp(bit se, bit [NW*W-1:0] sg, bit [SW-1:0] st, string tag);
        step(0, '0, '0, 0, se, sg, st, tag);
    endtask

    task automatic do_arm(string tag);
        step(0, '0, '0, 1, 1, '0, '0, tag);
    endtask

    function automatic bit [NW*W-1:0] sig1(int idx, bit [W-1:0] v);
        bit [NW*W-1:0] r = '0;
        r[idx*W +: W] = v;
        return r;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog: cycles actual=%0d expected<=150000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0; arm = 0; smp_en = 0;
        wp_sig = '0; st_sig = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset");
        rst = 0;
        smp(1, '0, '0, "R1 after reset");
        // R2: not armed yet, matching value does not fire
        wr(0, wp_word(1, 0, 8'h5A, 8'h00), "R11 write wp0");
        smp(1, sig1(0, 8'h5A), '0, "R2 no arm no fire");
        // R3 level mode
        do_arm("R2 arm");
        smp(1, sig1(0, 8'h11), '0, "R3 mismatch");
        smp(1, sig1(0, 8'h5A), '0, "R3 level hit");
        smp(1, sig1(0, 8'h5A), '0, "R9 pulse ends");
        smp(1, sig1(0, 8'h5A), '0, "R9 stays disarmed");
        // R4/R5 change mode
        wr(0, wp_word(0, 0, 8'h00, 8'h00), "R7 disable wp0");
        wr(1, wp_word(1, 1, 8'h05, 8'h06), "R11 write wp1 change");
        smp(1, sig1(1, 8'h05), '0, "R5 pre-arm A");
        do_arm("R5 arm");
        smp(1, sig1(1, 8'h06), '0, "R5 first sample B");
        smp(1, sig1(1, 8'h05), '0, "R4 A sample");
        smp(0, sig1(1, 8'h09), '0, "R10 gap ignored");
        smp(0, sig1(1, 8'h06), '0, "R10 B without strobe");
        smp(1, sig1(1, 8'h06), '0, "R4 change hit");
        smp(1, '0, '0, "R9 one pulse");
        // R5 arm between A and B
        do_arm("R2 rearm");
        smp(1, sig1(1, 8'h05), '0, "R4 A");
        step(0, '0, '0, 1, 1, sig1(1, 8'h06), '0, "R5 arm on B");
        smp(1, sig1(1, 8'h06), '0, "R5 B after arm");
        // R6/R7 AND of breakpoint and watchpoint
        wr(1, wp_word(0, 0, 0, 0), "R7 disable wp1");
        wr(4, bp_word(1, 4'h6), "R11 write bp0");
        wr(2, wp_word(1, 0, 8'h01, 8'h00), "R11 write wp2");
        do_arm("R7 arm");
        smp(1, sig1(2, 8'h00), 4'h6, "R7 only bp true");
        smp(1, sig1(2, 8'h01), 4'h3, "R7 only wp true");
        smp(1, sig1(2, 8'h01), 4'h6, "R7 both true");
        wr(2, wp_word(0, 0, 0, 0), "R7 disable wp2");
        do_arm("R6 arm");
        smp(1, '0, 4'h2, "R6 wrong state");
        smp(1, '0, 4'h6, "R6 state hit");
        // R8 no enables, R11 out-of-range writes
        wr(4, bp_word(0, 0), "R8 disable bp0");
        wr(7, wp_word(1, 0, 0, 0), "R11 unused address");
        wr(6, wp_word(1, 0, 0, 0), "R11 unused address");
        do_arm("R8 arm");
        for (int k = 0; k < 8; k++) smp(1, '0, '0, "R8 never fires");
        // random phase
        for (int k = 0; k < 3000; k++) begin
            bit [NW*W-1:0] sg;
            int r;
            for (int i = 0; i < NW; i++) sg[i*W +: W] = W'($urandom % 4);
            r = int'($urandom % 16);
            if (r == 0)
                step(1, AW'($urandom % (NW + NB + 1)),
                     wp_word(1'($urandom % 3 != 0), 1'($urandom), W'($urandom % 4), W'($urandom % 4)),
                     0, 1'($urandom), sg, SW'($urandom % 4), "R7 random cfg");
            else if (r == 1)
                step(0, '0, '0, 1, 1, sg, SW'($urandom % 4), "R2 random arm");
            else
                step(0, '0, '0, 0, 1'($urandom % 4 != 0), sg, SW'($urandom % 4), "R4 random sample");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule